// File: doc/BRIEF.md
# SHA-256 Compression Engine with Midstate Cache

This block is a SHA-256 compression engine for signature workloads that hash a very large number of short messages which all begin with the same constant 512-bit block and all have the same total length. Software drives it with single-cycle commands on a narrow command port, supplies 512-bit data blocks, and reads a 256-bit digest.

The engine keeps a working chaining state. Once the constant first block has been compressed, that state can be copied into an internal cache register. Every later message with the same prefix restores the cached state with a single command and compresses only its remaining blocks. The caller never builds the padding. The total message length is preset as a 64-bit bit count, and the final command pads the last data block in hardware from that count. When the pad and length field do not fit, the final command adds a second padding block on its own.

Each compression runs 64 rounds at one round per clock. The message schedule is expanded on the fly from a 16-word window. A busy flag covers every compression, and a one-cycle done pulse ends it.

Top module: `sha_mid_core`

## Requirements
- R1: After reset, busy, done and midErr are 0, digest is all zeros, midValid is 0 (the cache holds nothing), and the working state holds the standard SHA-256 initial value.
- R2: Command codes on cmdCode are INIT=0, SAVE_MID=1, LOAD_MID=2, BLOCK=3 and FINAL=4. INIT loads the standard initial value into the working state. BLOCK compresses blockData into the working state. Word 0 of a block sits in bits 511:480, and the digest carries state word 0 in bits 255:224.
- R3: A command is accepted when cmdValid is high and busy is low. busy is high for 64 cycles per compressed block, and done rises 64 clock edges after the accepting edge (128 for a FINAL that needs an extra block). A command presented while busy is high has no effect.
- R4: FINAL takes n data bits from the top of blockData, with n = msgBitLen mod 512 and a remainder of 0 meaning 512. The engine keeps those n bits, writes a single 1 bit directly after them, fills the rest with zeros, and places msgBitLen in the low 64 bits. Only data bits are used; the lower bits of blockData are ignored.
- R5: When n > 447 (fewer than 65 bits left), FINAL compresses a second, generated block. That block holds zeros and the length in its low 64 bits, and for n = 512 it also carries the leading 1 bit in bit 511.
- R6: SAVE_MID copies the working state into the cache and sets midValid.
- R7: LOAD_MID with midValid high copies the cache into the working state and clears digest to zero. The digest of the following blocks equals the digest obtained by compressing the cached prefix block again.
- R8: LOAD_MID with midValid low raises midErr for exactly one cycle and leaves both the working state and digest unchanged.
- R9: done is a one-cycle pulse after every BLOCK and FINAL. digest is updated only when a FINAL completes, stays unchanged through BLOCK, and is cleared by INIT and by a valid LOAD_MID.
- R10: Codes 5, 6 and 7 are ignored. They start no compression and change neither the state, the digest nor the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command strobe |
| cmdCode | input | 3 | Command code |
| blockData | input | 512 | Data block, word 0 in the top bits |
| msgBitLen | input | 64 | Preset total message length in bits, sampled by FINAL |
| busy | output | 1 | Compression in progress; commands ignored |
| done | output | 1 | One-cycle pulse when a BLOCK or FINAL completes |
| midValid | output | 1 | Cache holds a saved state |
| midErr | output | 1 | One-cycle pulse after LOAD_MID with an empty cache |
| digest | output | 256 | Final hash value |

## Verification
Two functions can fall in the same cycle: the acceptance of a new command and the completion of a compression, which is the edge where busy drops and the state is summed. The bench provokes this by keeping an INIT asserted from the cycle after a BLOCK is accepted until the done pulse, so that the INIT is presented on the finishing edge itself. The bench then withdraws the INIT before the next edge. A following FINAL must give the digest of the chain that includes that BLOCK, which shows that the finishing edge did not accept the INIT. Latency is checked at the same time by counting edges to done.

// File: rtl/sha_mid_pkg.sv
package sha_mid_pkg;
  localparam int WORD_W      = 32;
  localparam int STATE_WORDS = 8;
  localparam int BLOCK_WORDS = 16;
  localparam int ROUNDS      = 64;
  localparam int BLOCK_W     = WORD_W * BLOCK_WORDS;
  localparam int STATE_W     = WORD_W * STATE_WORDS;
  localparam int LEN_W       = 64;
  localparam int CNT_W       = $clog2(ROUNDS);
  localparam int NBITS_W     = $clog2(BLOCK_W) + 1;
  localparam int MAX_ONE_BLK = BLOCK_W - LEN_W - 1;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    CMD_INIT     = 3'd0,
    CMD_SAVE_MID = 3'd1,
    CMD_LOAD_MID = 3'd2,
    CMD_BLOCK    = 3'd3,
    CMD_FINAL    = 3'd4
  } cmd_e;

  typedef struct packed {
    logic             loadIv;
    logic             saveMid;
    logic             loadMid;
    logic             startBlk;
    logic             padFirst;
    logic             step;
    logic             lastRound;
    logic             chainExtra;
    logic             latchDigest;
    logic [CNT_W-1:0] roundIdx;
  } strobe_t;

  localparam logic [0:STATE_WORDS-1][WORD_W-1:0] IV_TAB = {
    32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
    32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};

  localparam logic [0:ROUNDS-1][WORD_W-1:0] K_TAB = {
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2};

  function automatic word_t rotr(word_t x, int unsigned n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t bigSig0(word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic word_t bigSig1(word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic word_t smlSig0(word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t smlSig1(word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction
endpackage

// File: rtl/sha_mid_ctrl.sv
module sha_mid_ctrl
  import sha_mid_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdCode,
  input  logic       padExtra,
  output strobe_t    stb,
  output logic       busy,
  output logic       done
);
  logic             busyQ, finalQ, extraQ, secondQ, doneQ;
  logic [CNT_W-1:0] rndQ;
  logic             accept;

  always_comb begin
    accept          = cmdValid && !busyQ;
    stb             = '0;
    stb.loadIv      = accept && (cmdCode == CMD_INIT);
    stb.saveMid     = accept && (cmdCode == CMD_SAVE_MID);
    stb.loadMid     = accept && (cmdCode == CMD_LOAD_MID);
    stb.padFirst    = accept && (cmdCode == CMD_FINAL);
    stb.startBlk    = accept && ((cmdCode == CMD_BLOCK) || (cmdCode == CMD_FINAL));
    stb.step        = busyQ;
    stb.lastRound   = busyQ && (rndQ == CNT_W'(ROUNDS - 1));
    stb.chainExtra  = stb.lastRound && finalQ && extraQ && !secondQ;
    stb.latchDigest = stb.lastRound && finalQ && !stb.chainExtra;
    stb.roundIdx    = rndQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      finalQ  <= 1'b0;
      extraQ  <= 1'b0;
      secondQ <= 1'b0;
      doneQ   <= 1'b0;
      rndQ    <= '0;
    end else begin
      doneQ <= stb.lastRound && !stb.chainExtra;
      if (stb.startBlk) begin
        busyQ   <= 1'b1;
        rndQ    <= '0;
        finalQ  <= stb.padFirst;
        extraQ  <= padExtra;
        secondQ <= 1'b0;
      end else if (busyQ) begin
        rndQ <= rndQ + 1'b1;
        if (stb.chainExtra) secondQ <= 1'b1;
        else if (stb.lastRound) busyQ <= 1'b0;
      end
    end
  end

  assign busy = busyQ;
  assign done = doneQ;
endmodule

// File: rtl/sha_mid_dp.sv
module sha_mid_dp
  import sha_mid_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [BLOCK_W-1:0] blockData,
  input  logic [LEN_W-1:0]   msgBitLen,
  output logic               padExtra,
  output logic               midValid,
  output logic               midErr,
  output logic [STATE_W-1:0] digest
);
  word_t hQ     [STATE_WORDS];
  word_t cacheQ [STATE_WORDS];
  word_t stQ    [STATE_WORDS];
  word_t nxt    [STATE_WORDS];
  word_t sum    [STATE_WORDS];
  word_t wQ     [BLOCK_WORDS];
  word_t t1, t2, wNew;
  logic [LEN_W-1:0]   lenQ;
  logic [NBITS_W-1:0] nIn;
  logic [BLOCK_W-1:0] keepMask, markBit, lenField, feedBlk, extraBlk;
  logic               midValidQ, midErrQ;
  logic [STATE_W-1:0] digestQ;

  // Padding of the final data block, built from the preset length.
  always_comb begin
    nIn      = (msgBitLen[NBITS_W-2:0] == '0) ? NBITS_W'(BLOCK_W) : {1'b0, msgBitLen[NBITS_W-2:0]};
    padExtra = nIn > NBITS_W'(MAX_ONE_BLK);
    keepMask = ~({BLOCK_W{1'b1}} >> nIn);
    markBit  = {1'b1, {(BLOCK_W-1){1'b0}}} >> nIn;
    lenField = padExtra ? '0 : {{(BLOCK_W-LEN_W){1'b0}}, msgBitLen};
    feedBlk  = stb.padFirst ? ((blockData & keepMask) | markBit | lenField) : blockData;
    extraBlk = {(lenQ[NBITS_W-2:0] == '0), {(BLOCK_W-LEN_W-1){1'b0}}, lenQ};
  end

  // One compression round and one schedule step.
  always_comb begin
    t1 = stQ[7] + bigSig1(stQ[4]) + ((stQ[4] & stQ[5]) ^ (~stQ[4] & stQ[6]))
       + K_TAB[stb.roundIdx] + wQ[0];
    t2 = bigSig0(stQ[0]) + ((stQ[0] & stQ[1]) ^ (stQ[0] & stQ[2]) ^ (stQ[1] & stQ[2]));
    nxt[0] = t1 + t2;
    nxt[1] = stQ[0];
    nxt[2] = stQ[1];
    nxt[3] = stQ[2];
    nxt[4] = stQ[3] + t1;
    nxt[5] = stQ[4];
    nxt[6] = stQ[5];
    nxt[7] = stQ[6];
    wNew   = smlSig1(wQ[14]) + wQ[9] + smlSig0(wQ[1]) + wQ[0];
    for (int i = 0; i < STATE_WORDS; i++) sum[i] = hQ[i] + nxt[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STATE_WORDS; i++) begin
        hQ[i]     <= IV_TAB[i];
        cacheQ[i] <= '0;
        stQ[i]    <= '0;
      end
      for (int k = 0; k < BLOCK_WORDS; k++) wQ[k] <= '0;
      lenQ      <= '0;
      midValidQ <= 1'b0;
      midErrQ   <= 1'b0;
      digestQ   <= '0;
    end else begin
      midErrQ <= stb.loadMid && !midValidQ;
      if (stb.loadIv) begin
        for (int i = 0; i < STATE_WORDS; i++) hQ[i] <= IV_TAB[i];
        digestQ <= '0;
      end
      if (stb.saveMid) begin
        for (int i = 0; i < STATE_WORDS; i++) cacheQ[i] <= hQ[i];
        midValidQ <= 1'b1;
      end
      if (stb.loadMid && midValidQ) begin
        for (int i = 0; i < STATE_WORDS; i++) hQ[i] <= cacheQ[i];
        digestQ <= '0;
      end
      if (stb.startBlk) begin
        for (int i = 0; i < STATE_WORDS; i++) stQ[i] <= hQ[i];
        for (int k = 0; k < BLOCK_WORDS; k++) wQ[k] <= feedBlk[BLOCK_W-1-WORD_W*k -: WORD_W];
        if (stb.padFirst) lenQ <= msgBitLen;
      end else if (stb.step) begin
        if (stb.lastRound) begin
          for (int i = 0; i < STATE_WORDS; i++) hQ[i] <= sum[i];
        end
        if (stb.chainExtra) begin
          for (int i = 0; i < STATE_WORDS; i++) stQ[i] <= sum[i];
          for (int k = 0; k < BLOCK_WORDS; k++) wQ[k] <= extraBlk[BLOCK_W-1-WORD_W*k -: WORD_W];
        end else begin
          for (int i = 0; i < STATE_WORDS; i++) stQ[i] <= nxt[i];
          for (int k = 0; k < BLOCK_WORDS-1; k++) wQ[k] <= wQ[k+1];
          wQ[BLOCK_WORDS-1] <= wNew;
        end
      end
      if (stb.latchDigest) begin
        for (int i = 0; i < STATE_WORDS; i++) digestQ[STATE_W-1-WORD_W*i -: WORD_W] <= sum[i];
      end
    end
  end

  assign midValid = midValidQ;
  assign midErr   = midErrQ;
  assign digest   = digestQ;
endmodule

// File: rtl/sha_mid_core.sv
module sha_mid_core
  import sha_mid_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           cmdValid,
  input  logic [2:0]     cmdCode,
  input  logic [511:0]   blockData,
  input  logic [63:0]    msgBitLen,
  output logic           busy,
  output logic           done,
  output logic           midValid,
  output logic           midErr,
  output logic [255:0]   digest
);
  strobe_t stb;
  logic    padExtra;

  sha_mid_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdCode  (cmdCode),
    .padExtra (padExtra),
    .stb      (stb),
    .busy     (busy),
    .done     (done)
  );

  sha_mid_dp i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .blockData (blockData),
    .msgBitLen (msgBitLen),
    .padExtra  (padExtra),
    .midValid  (midValid),
    .midErr    (midErr),
    .digest    (digest)
  );
endmodule

// File: rtl/sha_mid_chk.sv
module sha_mid_chk (
  input logic         clk,
  input logic         rstN,
  input logic         cmdValid,
  input logic [2:0]   cmdCode,
  input logic         busy,
  input logic         done,
  input logic         midValid,
  input logic         midErr,
  input logic [255:0] digest
);
  logic takeIdle;
  assign takeIdle = cmdValid && !busy;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R3
  AST_BLOCK_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (takeIdle && (cmdCode == 3'd3 || cmdCode == 3'd4)) |=> busy); // R3
  AST_SAVE_SETS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (takeIdle && cmdCode == 3'd1) |=> midValid); // R6
  AST_EMPTY_LOAD_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (takeIdle && cmdCode == 3'd2 && !midValid) |=> midErr); // R8
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    midErr |=> !midErr); // R8
  AST_DIGEST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(takeIdle && (cmdCode == 3'd0 || cmdCode == 3'd2)) |=> ($stable(digest) || done)); // R9
  AST_IGNORED_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (takeIdle && cmdCode > 3'd4) |=> (!busy && !midErr && $stable(digest))); // R10
endmodule

bind sha_mid_core sha_mid_chk i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cmdValid (cmdValid),
  .cmdCode  (cmdCode),
  .busy     (busy),
  .done     (done),
  .midValid (midValid),
  .midErr   (midErr),
  .digest   (digest)
);

// File: tb/test_sha_mid_core.sv
module test_sha_mid_core;
  import sha_mid_pkg::*;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cmdValid = 1'b0;
  logic [2:0]   cmdCode = 3'd0;
  logic [511:0] blockData = '0;
  logic [63:0]  msgBitLen = '0;
  logic         busy, done, midValid, midErr;
  logic [255:0] digest;

  int nChk = 0;
  int nFail = 0;
  bit finished = 0;

  logic [255:0] expQ[$];
  string        reqQ[$];

  logic [255:0] mH, mCache, mDig;

  sha_mid_core i_sha_mid_core (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .blockData(blockData), .msgBitLen(msgBitLen), .busy(busy), .done(done),
    .midValid(midValid), .midErr(midErr), .digest(digest));

  always #4 clk = ~clk;

  localparam logic [255:0] IV_REF =
    256'h6a09e667bb67ae853c6ef372a54ff53a510e527f9b05688c1f83d9ab5be0cd19;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rr(logic [31:0] x, int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [255:0] refCompress(logic [255:0] h, logic [511:0] blk);
    logic [31:0] w[64];
    logic [31:0] v[8];
    logic [31:0] s1, s0, ch, mj, x1, x2;
    logic [255:0] r;
    for (int t = 0; t < 16; t++) w[t] = blk[511-32*t -: 32];
    for (int t = 16; t < 64; t++) begin
      s0 = rr(w[t-15], 7) ^ rr(w[t-15], 18) ^ (w[t-15] >> 3);
      s1 = rr(w[t-2], 17) ^ rr(w[t-2], 19) ^ (w[t-2] >> 10);
      w[t] = w[t-16] + s0 + w[t-7] + s1;
    end
    for (int i = 0; i < 8; i++) v[i] = h[255-32*i -: 32];
    for (int t = 0; t < 64; t++) begin
      s1 = rr(v[4], 6) ^ rr(v[4], 11) ^ rr(v[4], 25);
      ch = (v[4] & v[5]) ^ (~v[4] & v[6]);
      x1 = v[7] + s1 + ch + K_TAB[t] + w[t];
      s0 = rr(v[0], 2) ^ rr(v[0], 13) ^ rr(v[0], 22);
      mj = (v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]);
      x2 = s0 + mj;
      v[7] = v[6]; v[6] = v[5]; v[5] = v[4]; v[4] = v[3] + x1;
      v[3] = v[2]; v[2] = v[1]; v[1] = v[0]; v[0] = x1 + x2;
    end
    for (int i = 0; i < 8; i++) r[255-32*i -: 32] = h[255-32*i -: 32] + v[i];
    return r;
  endfunction

  // Reference padding and final compression, written from R4 and R5.
  function automatic logic [255:0] refFinal(logic [255:0] h, logic [511:0] data, logic [63:0] len);
    int n;
    logic [1023:0] buf2;
    n = (len[8:0] == 0) ? 512 : int'(len[8:0]);
    buf2 = {data, 512'b0};
    for (int b = 0; b < 1024; b++) if (1023 - b >= n) buf2[b] = 1'b0;
    buf2[1023 - n] = 1'b1;
    if (n + 65 <= 512) begin
      buf2[575:512] = len;
      return refCompress(h, buf2[1023:512]);
    end
    buf2[63:0] = len;
    return refCompress(refCompress(h, buf2[1023:512]), buf2[511:0]);
  endfunction

  function automatic logic [511:0] mkBlk(int seed);
    logic [511:0] b;
    for (int k = 0; k < 16; k++) b[511-32*k -: 32] = 32'h9e3779b9 * (seed + 1) + 32'h01010101 * k;
    return b;
  endfunction

  task automatic issue(input logic [2:0] code, input logic [511:0] data, input logic [63:0] len);
    @(negedge clk);
    cmdValid = 1'b1; cmdCode = code; blockData = data; msgBitLen = len;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic waitDone(input int expLat, input string req);
    int lat = 0;
    while (!done) begin
      @(negedge clk);
      lat++;
    end
    check(lat == expLat, req, "done latency", 256'(lat), 256'(expLat));
  endtask

  task automatic doInit();
    issue(CMD_INIT, '0, '0);
    mH = IV_REF; mDig = '0;
  endtask

  task automatic doBlock(input logic [511:0] d, input string req);
    mH = refCompress(mH, d);
    expQ.push_back(mDig); reqQ.push_back(req);
    issue(CMD_BLOCK, d, '0);
    waitDone(64, req);
  endtask

  task automatic doFinal(input logic [511:0] d, input logic [63:0] len, input int lat, input string req);
    mH = refFinal(mH, d, len); mDig = mH;
    expQ.push_back(mDig); reqQ.push_back(req);
    issue(CMD_FINAL, d, len);
    waitDone(lat, req);
  endtask

  // Scoreboard monitor: compares the digest at every done pulse.
  always @(negedge clk) begin
    if (rstN && done) begin
      if (expQ.size() == 0) check(1'b0, "R9", "unexpected done", digest, '0);
      else check(digest == expQ[0], reqQ[0], "digest at done", digest, expQ[0]);
      if (expQ.size() != 0) begin
        void'(expQ.pop_front());
        void'(reqQ.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++; nChk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic [255:0] savedDig;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 0, "R1", "busy", 256'(busy), 0);
    check(done == 0, "R1", "done", 256'(done), 0);
    check(digest == 0, "R1", "digest", digest, 0);
    check(midValid == 0, "R1", "midValid", 256'(midValid), 0);
    check(midErr == 0, "R1", "midErr", 256'(midErr), 0);
    rstN = 1'b1;
    mH = IV_REF; mDig = '0;

    // R1 + R4: state after reset is the IV; single-block known answer
    doFinal({24'h616263, 488'b0}, 64'd24, 64, "R4");
    check(digest == 256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad,
          "R2", "known answer", digest, 256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad);

    // R8: LOAD_MID with empty cache
    savedDig = digest;
    issue(CMD_LOAD_MID, '0, '0);
    check(midErr == 1, "R8", "midErr pulse", 256'(midErr), 1);
    @(negedge clk);
    check(midErr == 0, "R8", "midErr drop", 256'(midErr), 0);
    check(digest == savedDig, "R8", "digest unchanged", digest, savedDig);
    doBlock(mkBlk(1), "R9");
    check(digest == savedDig, "R9", "digest held over BLOCK", digest, savedDig);
    doFinal(mkBlk(2), 64'd1224, 64, "R8");

    // R10: unused codes
    savedDig = digest;
    issue(3'd7, mkBlk(3), 64'd100);
    check(busy == 0, "R10", "no busy", 256'(busy), 0);
    issue(3'd5, mkBlk(3), 64'd100);
    check(digest == savedDig, "R10", "digest unchanged", digest, savedDig);
    check(midErr == 0, "R10", "no midErr", 256'(midErr), 0);

    // R9: INIT clears digest
    doInit();
    @(negedge clk);
    check(digest == 0, "R9", "INIT clears digest", digest, 0);

    // R5: extra block cases
    doBlock(mkBlk(4), "R2");
    doFinal(mkBlk(5), 64'd960, 128, "R5");
    doInit();
    doFinal(mkBlk(6), 64'd512, 128, "R5");
    doInit();
    doFinal(mkBlk(7), 64'd447, 64, "R4");

    // R6 + R7: midstate save and restore
    doInit();
    doBlock(mkBlk(8), "R2");
    issue(CMD_SAVE_MID, '0, '0);
    mCache = mH;
    check(midValid == 1, "R6", "midValid", 256'(midValid), 1);
    doFinal(mkBlk(9), 64'd612, 64, "R6");
    issue(CMD_LOAD_MID, '0, '0);
    mH = mCache; mDig = '0;
    check(digest == 0, "R7", "LOAD_MID clears digest", digest, 0);
    doFinal(mkBlk(10), 64'd812, 64, "R7");
    check(digest == refFinal(refCompress(IV_REF, mkBlk(8)), mkBlk(10), 64'd812),
          "R7", "restored chain", digest, refFinal(refCompress(IV_REF, mkBlk(8)), mkBlk(10), 64'd812));
    issue(CMD_LOAD_MID, '0, '0);
    mH = mCache; mDig = '0;
    doBlock(mkBlk(11), "R7");
    doFinal(mkBlk(12), 64'd1524, 128, "R7");

    // R3: INIT held across the finishing edge of a BLOCK is ignored
    doInit();
    mH = refCompress(mH, mkBlk(13));
    expQ.push_back(mDig); reqQ.push_back("R3");
    @(negedge clk);
    cmdValid = 1'b1; cmdCode = CMD_BLOCK; blockData = mkBlk(13);
    @(negedge clk);
    cmdCode = CMD_INIT;
    check(busy == 1, "R3", "busy after accept", 256'(busy), 1);
    while (!done) @(negedge clk);
    cmdValid = 1'b0;
    doFinal(mkBlk(14), 64'd1088, 64, "R3");

    // R1: reset empties the cache
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    check(midValid == 0, "R1", "cache invalid after reset", 256'(midValid), 0);
    issue(CMD_LOAD_MID, '0, '0);
    check(midErr == 1, "R1", "LOAD_MID after reset", 256'(midErr), 1);

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R9", "pending results", 256'(expQ.size()), 0);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule